// File: doc/BRIEF.md
# Entropy Stream Byte Packer

This block sits at the end of a baseline image encoder's entropy coding stage. The luma and the two chroma coding paths share one input port. Each path offers code words of up to 32 bits, each with a bit count. The packer appends the bits of each word, most significant first, to a bit accumulator. It breaks the accumulated stream into bytes and places the bytes in a small output queue. The consumer drains that queue through a valid/ready pair.

The paths take turns in a fixed rotation: luma, then blue-difference chroma, then red-difference chroma, one 8x8 block each. The `turn_comp` output names the path whose words are accepted. A producer ends its block by raising `in_blk_end` with its last word. Any data byte equal to 0xFF is followed by an inserted 0x00 byte, so that a decoder never mistakes data for a marker.

A word flagged `in_eoi` closes the image. The packer first completes any partial byte by filling it with 1 bits. It then appends the two-byte end-of-image marker 0xFF 0xD9 and returns to the luma turn.

Top module: `entropy_byte_packer`

## Requirements
- R1: A word is taken on a clock edge where `in_valid` and `in_ready` are both high. Its low `in_len` bits are appended to the stream, most significant bit first. The output bytes are the stream cut into consecutive 8-bit groups, with the earliest bit in bit 7, delivered in order with none lost or duplicated.
- R2: A length above 32 is treated as 32. A length of 0 adds no bits.
- R3: Every data byte equal to 0xFF is immediately followed in the output by a 0x00 byte.
- R4: `turn_comp` encodes the turn as 0 for luma, 1 for blue chroma and 2 for red chroma. It is 0 after reset. It advances 0→1→2→0 when a word with `in_blk_end` is taken. `in_ready` is low for any word whose `in_comp` differs from `turn_comp`, and such a word adds nothing to the output.
- R5: Taking a word with `in_eoi` triggers the end-of-image sequence. Any 1 to 7 pending bits are padded with 1 bits to a full byte, and that byte is stuffed if it equals 0xFF. The bytes 0xFF 0xD9 follow, with no 0x00 after this 0xFF. The turn then returns to 0. With no pending bits, no pad byte is emitted.
- R6: `in_ready` stays low from the edge that takes an end-of-image word until its marker has been queued.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R8: After reset, `out_valid` is low, `turn_comp` is 0, and `in_ready` is high for a luma word.
- R9: When the output is stalled, the input is held off through `in_ready` and no byte is dropped. A new word is taken only when fewer than 8 bits are pending. A byte, together with any stuffed 0x00, is queued only when the queue has two free places.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A code word is offered |
| in_ready | output | 1 | The offered word is taken at this edge |
| in_code | input | CODE_W (32) | Code bits, right-aligned |
| in_len | input | LEN_W (6) | Number of valid code bits, 0 to 32 |
| in_comp | input | 2 | Offering path: 0 luma, 1 blue chroma, 2 red chroma |
| in_blk_end | input | 1 | Last word of this path's block |
| in_eoi | input | 1 | Last word of the image |
| turn_comp | output | 2 | Path whose words are currently accepted |
| out_valid | output | 1 | A byte is available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Output byte |

## Verification
The bench targets five corner cases, each paired with the fault it would expose.

- **Stuffing:** 0xFF data bytes appear both inside long words and as the padded final byte. A design that skipped stuffing, or stuffed the marker's own 0xFF, would add or lose a 0x00 against the reference stream.
- **Length limits:** zero-length words and over-long lengths are sent. Mishandling them would shift every later bit.
- **Wrong turn:** words from a path whose turn it is not are offered. A design that took them would insert foreign bits into the stream.
- **Stalled output:** a fully stalled consumer, followed by random backpressure, exposes overflow of the two-byte stuffing write as dropped bytes and a held byte that changes.
- **End of image:** a flush with nothing pending shows whether a spurious pad byte is emitted.

// File: rtl/ebp_pkg.sv
package ebp_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_FLUSH = 2'd1,
    ST_MARK  = 2'd2
  } pk_state_e;

  localparam logic [1:0] TURN_Y  = 2'd0;
  localparam logic [1:0] TURN_CR = 2'd2;

  localparam logic [7:0] EOI_HI    = 8'hFF;
  localparam logic [7:0] EOI_LO    = 8'hD9;
  localparam logic [7:0] ZERO_BYTE = 8'h00;

  // rotation luma -> blue chroma -> red chroma -> luma
  function automatic logic [1:0] next_turn(input logic [1:0] t);
    return (t == TURN_CR) ? TURN_Y : t + 2'd1;
  endfunction

  function automatic logic needs_stuff(input logic [7:0] b);
    return b == 8'hFF;
  endfunction

  // n pending bits (1..7) sit in low[n-1:0]; move them to the top, fill with ones
  function automatic logic [7:0] pad_ones(input logic [7:0] low, input logic [3:0] n);
    logic [3:0] sh;
    sh = 4'd8 - n;
    return (low << sh) | (8'hFF >> n);
  endfunction

endpackage

// File: rtl/ebp_accum.sv
module ebp_accum #(
  parameter int CODE_W = 32,
  parameter int LEN_W  = 6,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              app_en,
  input  logic [CODE_W-1:0] app_code,
  input  logic [LEN_W-1:0]  app_len,
  input  logic              take_en,
  input  logic              clear_en,
  output logic [CNT_W-1:0]  level,
  output logic [7:0]        top_byte,
  output logic [7:0]        low_byte
);
  localparam int ACC_W = CODE_W + 8;

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] lvl_q;
  logic [ACC_W-1:0] code_ext;
  logic [ACC_W-1:0] keep_mask;
  logic [ACC_W-1:0] shifted;

  always_comb begin
    code_ext  = {{8{1'b0}}, app_code};
    keep_mask = ~({ACC_W{1'b1}} << app_len);
    shifted   = acc_q >> (lvl_q - CNT_W'(8));
  end

  assign top_byte = shifted[7:0];
  assign low_byte = acc_q[7:0];
  assign level    = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      lvl_q <= '0;
    end else if (app_en) begin
      acc_q <= (acc_q << app_len) | (code_ext & keep_mask);
      lvl_q <= lvl_q + CNT_W'(app_len);
    end else if (take_en) begin
      lvl_q <= lvl_q - CNT_W'(8);
    end else if (clear_en) begin
      lvl_q <= '0;
    end
  end
endmodule

// File: rtl/ebp_wfifo.sv
module ebp_wfifo #(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_two,
  input  logic [7:0]       wr_b0,
  input  logic [7:0]       wr_b1,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             not_empty,
  output logic             room2,
  output logic [LVL_W-1:0] level
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [LVL_W-1:0] cnt_q;
  logic [LVL_W-1:0] n_in, n_out;

  assign n_in      = wr_en ? (wr_two ? LVL_W'(2) : LVL_W'(1)) : '0;
  assign n_out     = rd_en ? LVL_W'(1) : '0;
  assign rd_data   = mem[rptr];
  assign not_empty = cnt_q != '0;
  assign room2     = (LVL_W'(DEPTH) - cnt_q) >= LVL_W'(2);
  assign level     = cnt_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wptr] <= wr_b0;
      if (wr_two) mem[wptr + PTR_W'(1)] <= wr_b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wptr <= wptr + (wr_two ? PTR_W'(2) : PTR_W'(1));
      if (rd_en) rptr <= rptr + PTR_W'(1);
      cnt_q <= cnt_q + n_in - n_out;
    end
  end
endmodule

// File: rtl/entropy_byte_packer.sv
module entropy_byte_packer
  import ebp_pkg::*;
#(
  parameter int CODE_W     = 32,
  parameter int LEN_W      = 6,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [1:0]        in_comp,
  input  logic              in_blk_end,
  input  logic              in_eoi,
  output logic [1:0]        turn_comp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data
);
  localparam int CNT_W = $clog2(CODE_W + 9);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  pk_state_e        state_q;
  logic [1:0]       turn_q;
  logic [CNT_W-1:0] acc_level;
  logic [7:0]       top_byte, low_byte, data_byte;
  logic [LEN_W-1:0] len_sat;
  logic             lvl_low, room2;
  logic [LVL_W-1:0] fifo_level;

  // named internal events for the checker
  logic ev_accept, ev_drain, ev_pad, ev_mark, ev_stuff;
  logic wr_en, wr_two;
  logic [7:0] wr_b0, wr_b1;

  assign len_sat   = (in_len > LEN_W'(CODE_W)) ? LEN_W'(CODE_W) : in_len;
  assign lvl_low   = acc_level < CNT_W'(8);
  assign in_ready  = (state_q == ST_RUN) && lvl_low && (in_comp == turn_q);
  assign turn_comp = turn_q;

  assign ev_accept = in_valid && in_ready;
  assign ev_drain  = !lvl_low && room2;
  assign ev_pad    = (state_q == ST_FLUSH) && lvl_low && (acc_level != '0) && room2;
  assign ev_mark   = (state_q == ST_MARK) && room2;

  assign data_byte = ev_pad ? pad_ones(low_byte, acc_level[3:0]) : top_byte;
  assign ev_stuff  = (ev_drain || ev_pad) && needs_stuff(data_byte);

  assign wr_en  = ev_drain || ev_pad || ev_mark;
  assign wr_two = ev_stuff || ev_mark;
  assign wr_b0  = ev_mark ? EOI_HI : data_byte;
  assign wr_b1  = ev_mark ? EOI_LO : ZERO_BYTE;

  ebp_accum #(
    .CODE_W(CODE_W),
    .LEN_W (LEN_W),
    .CNT_W (CNT_W)
  ) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .app_en  (ev_accept),
    .app_code(in_code),
    .app_len (len_sat),
    .take_en (ev_drain),
    .clear_en(ev_pad),
    .level   (acc_level),
    .top_byte(top_byte),
    .low_byte(low_byte)
  );

  ebp_wfifo #(
    .DEPTH(FIFO_DEPTH)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_two   (wr_two),
    .wr_b0    (wr_b0),
    .wr_b1    (wr_b1),
    .rd_en    (out_valid && out_ready),
    .rd_data  (out_data),
    .not_empty(out_valid),
    .room2    (room2),
    .level    (fifo_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      turn_q  <= TURN_Y;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (ev_accept && in_eoi)          state_q <= ST_FLUSH;
          else if (ev_accept && in_blk_end) turn_q  <= next_turn(turn_q);
        end
        ST_FLUSH: if (acc_level == '0) state_q <= ST_MARK;
        ST_MARK: begin
          if (ev_mark) begin
            state_q <= ST_RUN;
            turn_q  <= TURN_Y;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/ebp_checks.sv
module ebp_checks #(
  parameter int CODE_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = 4,
  parameter int CNT_W      = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic [1:0]       in_comp,
  input logic [1:0]       turn_comp,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             ev_accept,
  input logic             ev_drain,
  input logic             ev_pad,
  input logic             ev_mark,
  input logic             wr_two,
  input logic [7:0]       wr_b0,
  input logic [7:0]       wr_b1,
  input logic [LVL_W-1:0] fifo_level,
  input logic [CNT_W-1:0] acc_level,
  input logic [1:0]       state
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_stuff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drain || ev_pad) && wr_b0 == 8'hFF |-> wr_two && wr_b1 == 8'h00);

  p_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mark |-> wr_two && wr_b0 == 8'hFF && wr_b1 == 8'hD9);

  p_turn_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mark |=> turn_comp == 2'd0);

  p_turn_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> in_comp == turn_comp);

  p_turn_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    turn_comp != 2'd3);

  p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd0 |-> !in_ready);

  p_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_level >= CNT_W'(8) |-> !in_ready);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(FIFO_DEPTH));

  p_acc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_level <= CNT_W'(CODE_W + 7));
endmodule

bind entropy_byte_packer ebp_checks #(
  .CODE_W    (CODE_W),
  .FIFO_DEPTH(FIFO_DEPTH),
  .LVL_W     (LVL_W),
  .CNT_W     (CNT_W)
) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .in_comp   (in_comp),
  .turn_comp (turn_comp),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .ev_accept (ev_accept),
  .ev_drain  (ev_drain),
  .ev_pad    (ev_pad),
  .ev_mark   (ev_mark),
  .wr_two    (wr_two),
  .wr_b0     (wr_b0),
  .wr_b1     (wr_b1),
  .fifo_level(fifo_level),
  .acc_level (acc_level),
  .state     (state_q)
);

// File: tb/tb_entropy_byte_packer.sv
`timescale 1ns/1ps
module tb_entropy_byte_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_code = '0;
  logic [5:0]  in_len = '0;
  logic [1:0]  in_comp = '0;
  logic        in_blk_end = 1'b0;
  logic        in_eoi = 1'b0;
  logic [1:0]  turn_comp;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;

  int n_chk = 0;
  int n_fail = 0;
  int rdy_mode = 0;
  int model_turn = 0;
  logic [7:0] exp_q[$];
  bit         bitq[$];
  bit         hold_pend = 0;
  logic [7:0] hold_val = '0;

  always #10 clk = ~clk;

  entropy_byte_packer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_len(in_len), .in_comp(in_comp),
    .in_blk_end(in_blk_end), .in_eoi(in_eoi), .turn_comp(turn_comp),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // stimulus table: {code[31:0], len[5:0], comp[1:0], blk_end, eoi, expect_taken}
  localparam int TBL_N = 8;
  localparam logic [42:0] TBL [TBL_N] = '{
    {32'h000000AB, 6'd8,  2'd0, 1'b0, 1'b0, 1'b1},
    {32'h00000003, 6'd2,  2'd1, 1'b0, 1'b0, 1'b0},
    {32'h000000FF, 6'd8,  2'd0, 1'b1, 1'b0, 1'b1},
    {32'h00000005, 6'd3,  2'd1, 1'b1, 1'b0, 1'b1},
    {32'h00000000, 6'd0,  2'd2, 1'b0, 1'b0, 1'b1},
    {32'h00000001, 6'd5,  2'd0, 1'b0, 1'b0, 1'b0},
    {32'hFFFFFFFF, 6'd40, 2'd2, 1'b1, 1'b0, 1'b1},
    {32'h0000007F, 6'd7,  2'd0, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic model_byte(input logic [7:0] b);
    exp_q.push_back(b);
    if (b == 8'hFF) exp_q.push_back(8'h00);
  endtask

  task automatic model_word(input logic [31:0] code, input int len, input bit eoi);
    int n;
    logic [7:0] b;
    n = (len > 32) ? 32 : len;
    for (int i = n - 1; i >= 0; i--) bitq.push_back(code[i]);
    while (bitq.size() >= 8) begin
      for (int k = 0; k < 8; k++) b[7-k] = bitq.pop_front();
      model_byte(b);
    end
    if (eoi) begin
      if (bitq.size() > 0) begin
        b = 8'hFF;
        for (int k = 0; bitq.size() > 0; k++) b[7-k] = bitq.pop_front();
        model_byte(b);
      end
      exp_q.push_back(8'hFF);
      exp_q.push_back(8'hD9);
    end
  endtask

  task automatic send(input logic [31:0] code, input logic [5:0] len, input logic [1:0] comp,
                      input bit blk, input bit eoi, input bit expect_taken);
    int w;
    @(negedge clk);
    in_valid = 1'b1; in_code = code; in_len = len; in_comp = comp;
    in_blk_end = blk; in_eoi = eoi;
    #2;
    if (!expect_taken) begin
      for (int r = 0; r < 4; r++) begin
        check(in_ready == 1'b0, "R4", "off-turn word refused", int'(in_ready), 0);
        @(negedge clk); #2;
      end
      in_valid = 1'b0;
      return;
    end
    w = 0;
    while (!in_ready && w < 2000) begin
      @(negedge clk); #2; w++;
    end
    check(in_ready == 1'b1, "R1", "word taken", int'(in_ready), 1);
    @(posedge clk);
    model_word(code, int'(len), eoi);
    if (eoi) model_turn = 0;
    else if (blk) model_turn = (model_turn == 2) ? 0 : model_turn + 1;
    #1 in_valid = 1'b0;
  endtask

  task automatic drain_wait(input string what);
    int w;
    w = 0;
    while (exp_q.size() != 0 && w < 5000) begin
      @(negedge clk); w++;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R1", what, exp_q.size(), 0);
  endtask

  // output monitor: acts between edges
  always @(negedge clk) begin
    if (rst_n) begin
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom % 3) != 0;
        default: out_ready = 1'b0;
      endcase
      #1;
      if (hold_pend)
        check(out_valid && out_data == hold_val, "R7", "held byte", int'(out_data), int'(hold_val));
      hold_pend = out_valid && !out_ready;
      hold_val  = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R1", "unexpected byte", int'(out_data), -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(out_data == e, "R1/R3/R5", "stream byte", int'(out_data), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    // R8: reset state
    @(negedge clk); #2;
    check(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);
    check(turn_comp == 2'd0, "R8", "turn after reset", int'(turn_comp), 0);
    in_comp = 2'd0; #1;
    check(in_ready == 1'b1, "R8", "ready for luma", int'(in_ready), 1);
    in_comp = 2'd1; #1;
    check(in_ready == 1'b0, "R4", "ready for chroma", int'(in_ready), 0);

    // table walk: R1 R2 R3 R4 R5
    rdy_mode = 0;
    for (int i = 0; i < TBL_N; i++)
      send(TBL[i][42:11], TBL[i][10:5], TBL[i][4:3], TBL[i][2], TBL[i][1], TBL[i][0]);
    @(negedge clk); in_comp = 2'd0; #2;
    check(in_ready == 1'b0, "R6", "ready during flush", int'(in_ready), 0);
    drain_wait("table stream complete");
    check(turn_comp == 2'd0, "R5", "turn after marker", int'(turn_comp), 0);

    // R5: pad byte that becomes 0xFF is stuffed
    send(32'h7F, 6'd7, 2'd0, 1'b0, 1'b1, 1'b1);
    drain_wait("R5 stuffed pad byte");
    // R5: nothing pending, marker only
    send(32'h0, 6'd0, 2'd0, 1'b0, 1'b1, 1'b1);
    drain_wait("R5 marker without pad");

    // R9: stalled consumer
    rdy_mode = 2;
    send(32'hFFFFFFFF, 6'd32, 2'd0, 1'b0, 1'b0, 1'b1);
    send(32'hFFFFFFFF, 6'd32, 2'd0, 1'b1, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    in_comp = 2'(model_turn); #2;
    check(in_ready == 1'b0, "R9", "input held off while stalled", int'(in_ready), 0);
    check(out_valid == 1'b1, "R9", "bytes waiting", int'(out_valid), 1);
    rdy_mode = 0;
    send(32'h1, 6'd1, 2'(model_turn), 1'b0, 1'b1, 1'b1);
    drain_wait("R9 stream after stall");

    // random words with random backpressure: R1 R2 R3 R4 R5
    rdy_mode = 1;
    for (int i = 0; i < 80; i++) begin
      logic [31:0] c;
      logic [5:0]  l;
      c = $urandom;
      if ((i % 5) == 0) c = 32'hFFFFFFFF;
      l = 6'($urandom % 41);
      send(c, l, 2'(model_turn), ($urandom % 4) == 0, i == 79, 1'b1);
    end
    drain_wait("random stream complete");
    check(turn_comp == 2'd0, "R5", "turn after random image", int'(turn_comp), 0);
    finish_up();
  end
endmodule